// File: doc/BRIEF.md
# Machine-Check Exception Capture Unit

This unit sits next to a simple processor core and gathers its hardware error indications: an L2 double-bit ECC error, the external machine-check pin, a bus transfer error acknowledge, a data-bus parity error and an address-bus parity error. Each indication is a single-cycle pulse sampled on the clock edge. When an error is seen, the unit chooses one of two outcomes. It can raise a recoverable machine-check exception. It can instead fall into a checkstop state that lasts until reset. The choice depends on the machine-check enable bit of the machine-state register and on a per-source enable mask.

When the unit takes an exception, it does four things:
- It saves the current instruction address into a saved-PC register.
- It builds a saved-status word with one cause bit per source and a copy of the lower half of the machine-state register.
- It loads a cleaned machine-state value in which the enable bit is cleared.
- It pulses three strobes for one cycle: an exception request, a redirect to a fixed vector, and a discard-pending-stores signal.

Because the enable bit is cleared on entry, a second error before software re-arms the unit ends in checkstop. Software re-arms by writing the machine-state register through a write port.

Bit numbers below use vector index (bit 0 = least significant). A big-endian architectural bit b sits at index 31-b.

Top module: `mchk_capture`

## Requirements
- R1: After reset:
  - `msr_o` equals the RESET_MSR parameter (default 32'h0000_1000, so the machine-check enable at index 12 is set).
  - `srr0_o` and `srr1_o` are zero.
  - No strobe is high and `checkstop_o` is low.
- R2: An error is taken as an exception under three conditions: `msr_o[12]` is 1, every asserted `err_src_i` bit has its `src_en_i` bit set, and the unit is not in checkstop. In that case, the cycle after the sampling edge, `mc_req_o`, `redirect_o` and `discard_o` are each high for exactly one cycle, and `redirect_addr_o` equals the VECTOR parameter.
- R3: On an exception, `srr1_o` holds the cause bits:
  - index 20 for `err_src_i[0]` (L2 double-bit ECC);
  - index 19 for `[1]` (machine-check pin);
  - index 18 for `[2]` (transfer error acknowledge);
  - index 17 for `[3]` (data-bus parity);
  - index 16 for `[4]` (address-bus parity).
  
  Each cause bit is zero when its source is absent, and indices 31..21 are zero.
- R4: On an exception, `srr1_o[15:0]` equals `msr_o[15:0]` as it was before entry.
- R5: On an exception, the new `msr_o` keeps only index 16 (interrupt little-endian) and index 6 (vector prefix). Index 0 is loaded from the old index 16, and every other bit is cleared, including the enable at index 12.
- R6: On an exception, `srr0_o` equals `pc_i` as sampled at the error edge.
- R7: An error that arrives while `msr_o[12]` is 0 sets `checkstop_o` one cycle after sampling, with no strobe.
- R8: An error with any asserted source whose `src_en_i` bit is 0 sets `checkstop_o` even when `msr_o[12]` is 1, with no strobe.
- R9: Checkstop is sticky until reset. While it is set, errors raise no strobe, and `msr_o`, `srr0_o` and `srr1_o` stay unchanged, even when `msr_wr_i` is asserted.
- R10: A second error after an exception, with no write to `msr_o` in between, causes checkstop.
- R11: When `msr_wr_i` is high outside checkstop and no exception is taken in that cycle, `msr_o` takes `msr_wdata_i` on the next edge. Writing index 12 back to 1 re-arms exception handling.
- R12: Several sources asserted in the same cycle produce one exception whose `srr1_o` has all their cause bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_src_i | input | 5 | Error pulses: [0] L2 ECC, [1] check pin, [2] transfer error, [3] data parity, [4] address parity |
| src_en_i | input | 5 | Per-source enable mask |
| pc_i | input | 32 | Address of the instruction executing or about to execute |
| msr_wr_i | input | 1 | Software write strobe for the machine-state register |
| msr_wdata_i | input | 32 | Write data for the machine-state register |
| msr_o | output | 32 | Machine-state register |
| srr0_o | output | 32 | Saved PC |
| srr1_o | output | 32 | Saved-status word |
| mc_req_o | output | 1 | One-cycle exception request |
| redirect_o | output | 1 | One-cycle redirect request to the vector |
| redirect_addr_o | output | 32 | Machine-check vector address |
| discard_o | output | 1 | One-cycle discard-pending-stores strobe |
| checkstop_o | output | 1 | Sticky halt indication |

## Verification
A wrong decision between exception and checkstop shows at the ports one cycle after the error edge, as a missing or unexpected request pulse or halt. A corrupted saved-status or machine-state image is visible in that same cycle on `srr1_o` and `msr_o`. A checkstop that fails to hold, or an enable bit that is not cleared on entry, only shows on the next error. For that reason the scenarios inject a second error after each exception and after each checkstop.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int XLEN      = 32;
  localparam int NSRC      = 5;
  // big-endian architectural bit positions
  localparam int CAUSE_BE0 = 11;
  localparam int ILE_BE    = 15;
  localparam int ME_BE     = 19;
  localparam int IP_BE     = 25;
  localparam int LE_BE     = 31;
  // little-endian indices derived from them
  localparam int ILE_IX    = XLEN - 1 - ILE_BE;
  localparam int ME_IX     = XLEN - 1 - ME_BE;
  localparam int IP_IX     = XLEN - 1 - IP_BE;
  localparam int LE_IX     = XLEN - 1 - LE_BE;
  localparam int CAUSE_HI  = XLEN - 1 - CAUSE_BE0;
  localparam int KEEP_W    = XLEN / 2;

  typedef enum logic [2:0] {
    SRC_L2ECC = 3'd0,
    SRC_CKPIN = 3'd1,
    SRC_XFER  = 3'd2,
    SRC_DPAR  = 3'd3,
    SRC_APAR  = 3'd4
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [XLEN-1:0] word_t;

  function automatic word_t status_image(src_vec_t src, word_t msr);
    word_t r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      r[CAUSE_HI - i] = src[i];
    end
    r[KEEP_W-1:0] = msr[KEEP_W-1:0];
    return r;
  endfunction

  function automatic word_t entry_state(word_t msr);
    word_t r;
    r = '0;
    r[ILE_IX] = msr[ILE_IX];
    r[IP_IX]  = msr[IP_IX];
    r[LE_IX]  = msr[ILE_IX];
    return r;
  endfunction
endpackage

// File: rtl/mchk_gate.sv
module mchk_gate
  import mchk_pkg::*;
(
  input  src_vec_t err,
  input  src_vec_t en,
  input  logic     me,
  input  logic     halted,
  output logic     take,
  output logic     stop
);
  logic any_err;
  logic masked;

  always_comb begin
    any_err = |err;
    masked  = |(err & ~en);
    take    = any_err && !halted && me && !masked;
    stop    = any_err && !halted && (!me || masked);
  end
endmodule

// File: rtl/mchk_image.sv
module mchk_image
  import mchk_pkg::*;
(
  input  src_vec_t src,
  input  word_t    msr_cur,
  output word_t    srr1_next,
  output word_t    msr_next
);
  always_comb begin
    srr1_next = status_image(src, msr_cur);
    msr_next  = entry_state(msr_cur);
  end
endmodule

// File: rtl/mchk_capture.sv
module mchk_capture
  import mchk_pkg::*;
#(
  parameter logic [31:0] VECTOR    = 32'h0000_0200,
  parameter logic [31:0] RESET_MSR = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  err_src_i,
  input  logic [4:0]  src_en_i,
  input  logic [31:0] pc_i,
  input  logic        msr_wr_i,
  input  logic [31:0] msr_wdata_i,
  output logic [31:0] msr_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic        mc_req_o,
  output logic        redirect_o,
  output logic [31:0] redirect_addr_o,
  output logic        discard_o,
  output logic        checkstop_o
);
  word_t msr_q, srr0_q, srr1_q;
  logic  req_q, halt_q;
  logic  take_w, stop_w;
  word_t srr1_w, msr_entry_w;

  mchk_gate u_gate (
    .err    (err_src_i),
    .en     (src_en_i),
    .me     (msr_q[ME_IX]),
    .halted (halt_q),
    .take   (take_w),
    .stop   (stop_w)
  );

  mchk_image u_image (
    .src       (err_src_i),
    .msr_cur   (msr_q),
    .srr1_next (srr1_w),
    .msr_next  (msr_entry_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q  <= RESET_MSR;
      srr0_q <= '0;
      srr1_q <= '0;
      req_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      req_q <= take_w;
      if (take_w) begin
        msr_q  <= msr_entry_w;
        srr0_q <= pc_i;
        srr1_q <= srr1_w;
      end else if (msr_wr_i && !halt_q) begin
        msr_q <= msr_wdata_i;
      end
      if (stop_w) halt_q <= 1'b1;
    end
  end

  assign msr_o           = msr_q;
  assign srr0_o          = srr0_q;
  assign srr1_o          = srr1_q;
  assign mc_req_o        = req_q;
  assign redirect_o      = req_q;
  assign discard_o       = req_q;
  assign redirect_addr_o = VECTOR;
  assign checkstop_o     = halt_q;
endmodule

// File: rtl/mchk_capture_sva.sv
module mchk_capture_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  err_src_i,
  input logic [31:0] msr_o,
  input logic [31:0] srr1_o,
  input logic        mc_req_o,
  input logic        redirect_o,
  input logic        discard_o,
  input logic        checkstop_o,
  input logic        take_w,
  input logic        stop_w
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mc_req_o |=> !mc_req_o); // R2
  AST_STROBES_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) (mc_req_o == redirect_o) && (mc_req_o == discard_o)); // R2
  AST_REQ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n) $rose(mc_req_o) |-> $past(|err_src_i)); // R2
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) mc_req_o |-> (srr1_o[31:21] == 11'd0)); // R3
  AST_ME_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) mc_req_o |-> !msr_o[12]); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) checkstop_o |=> checkstop_o); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) checkstop_o |-> !mc_req_o); // R9
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (checkstop_o && $past(checkstop_o)) |-> $stable(msr_o)); // R9
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(checkstop_o) |-> $past(stop_w)); // R7
  AST_TAKE_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(take_w && stop_w)); // R8
endmodule

bind mchk_capture mchk_capture_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_src_i   (err_src_i),
  .msr_o       (msr_o),
  .srr1_o      (srr1_o),
  .mc_req_o    (mc_req_o),
  .redirect_o  (redirect_o),
  .discard_o   (discard_o),
  .checkstop_o (checkstop_o),
  .take_w      (take_w),
  .stop_w      (stop_w)
);

// File: tb/mchk_capture_bench.sv
module mchk_capture_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] VEC = 32'h0000_0200;
  localparam logic [31:0] RST_MSR = 32'h0000_1000;
  localparam logic [31:0] ME_BIT = 32'h8000_0000 >> 19;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  err = '0;
  logic [4:0]  en = 5'h1f;
  logic [31:0] pc = '0;
  logic        wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] msr, srr0, srr1, raddr;
  logic        req, redir, disc, halt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  mchk_capture u_mchk_capture (
    .clk(clk), .rst_n(rst_n), .err_src_i(err), .src_en_i(en), .pc_i(pc),
    .msr_wr_i(wr), .msr_wdata_i(wdata), .msr_o(msr), .srr0_o(srr0),
    .srr1_o(srr1), .mc_req_o(req), .redirect_o(redir),
    .redirect_addr_o(raddr), .discard_o(disc), .checkstop_o(halt)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] want_srr1(logic [4:0] s, logic [31:0] m);
    logic [31:0] r = m & 32'h0000_FFFF;
    for (int i = 0; i < 5; i++)
      if (s[i]) r = r | (32'h8000_0000 >> (11 + i));
    return r;
  endfunction

  function automatic logic [31:0] want_msr(logic [31:0] m);
    logic [31:0] ile = m & (32'h8000_0000 >> 15);
    logic [31:0] ip  = m & (32'h8000_0000 >> 25);
    return ile | ip | ((ile != 0) ? 32'h1 : 32'h0);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; err = '0; wr = 0; en = 5'h1f;
    step(); step();
    rst_n = 1;
  endtask

  task automatic write_msr(logic [31:0] v);
    wr = 1; wdata = v;
    step();
    wr = 0;
  endtask

  task automatic fire(logic [4:0] s, logic [31:0] p);
    err = s; pc = p;
    step();
    err = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 msr", msr, RST_MSR);
    chk("R1 srr0", srr0, 32'h0);
    chk("R1 srr1", srr1, 32'h0);
    chk("R1 strobes", {29'd0, req, redir, disc}, 32'h0);
    chk("R1 halt", {31'd0, halt}, 32'h0);
  endtask

  task automatic t_single();
    for (int i = 0; i < 5; i++) begin
      logic [31:0] pat;
      pat = (32'h0001_0043 ^ (i * 32'h0102_0110)) | ME_BIT;
      do_reset();
      write_msr(pat);
      chk("R11 write", msr, pat);
      fire(5'b1 << i, 32'h1000_0000 + i * 4);
      chk("R2 req", {31'd0, req}, 32'h1);
      chk("R2 redirect", {31'd0, redir}, 32'h1);
      chk("R2 discard", {31'd0, disc}, 32'h1);
      chk("R2 vector", raddr, VEC);
      chk("R3 srr1 cause", srr1 & 32'hFFFF_0000, want_srr1(5'b1 << i, pat) & 32'hFFFF_0000);
      chk("R4 srr1 low", srr1 & 32'h0000_FFFF, pat & 32'h0000_FFFF);
      chk("R5 new msr", msr, want_msr(pat));
      chk("R6 srr0", srr0, 32'h1000_0000 + i * 4);
      chk("R2 no halt", {31'd0, halt}, 32'h0);
      step();
      chk("R2 pulse ends", {29'd0, req, redir, disc}, 32'h0);
    end
  endtask

  task automatic t_multi();
    do_reset();
    fire(5'b10101, 32'hABCD_0000);
    chk("R12 req", {31'd0, req}, 32'h1);
    chk("R12 srr1", srr1, want_srr1(5'b10101, RST_MSR));
    do_reset();
    fire(5'b11111, 32'h0000_0040);
    chk("R12 all srr1", srr1, want_srr1(5'b11111, RST_MSR));
  endtask

  task automatic t_me_off();
    do_reset();
    write_msr(32'h0000_00F0);
    fire(5'b00100, 32'h4);
    chk("R7 halt", {31'd0, halt}, 32'h1);
    chk("R7 no req", {31'd0, req}, 32'h0);
    chk("R7 srr1 untouched", srr1, 32'h0);
    write_msr(32'hFFFF_FFFF);
    chk("R9 msr frozen", msr, 32'h0000_00F0);
    fire(5'b00001, 32'h8);
    chk("R9 no req", {29'd0, req, redir, disc}, 32'h0);
    chk("R9 srr0 frozen", srr0, 32'h0);
    step(); step();
    chk("R9 sticky", {31'd0, halt}, 32'h1);
  endtask

  task automatic t_masked();
    do_reset();
    en = 5'b11101;
    fire(5'b00011, 32'h20);
    chk("R8 halt", {31'd0, halt}, 32'h1);
    chk("R8 no req", {31'd0, req}, 32'h0);
    chk("R8 msr kept", msr, RST_MSR);
    do_reset();
    en = 5'b11101;
    fire(5'b00001, 32'h24);
    chk("R8 enabled src taken", {31'd0, req}, 32'h1);
  endtask

  task automatic t_second();
    do_reset();
    fire(5'b01000, 32'h100);
    chk("R10 first req", {31'd0, req}, 32'h1);
    step();
    fire(5'b00010, 32'h104);
    chk("R10 halt", {31'd0, halt}, 32'h1);
    chk("R10 no req", {31'd0, req}, 32'h0);
    chk("R10 srr0 kept", srr0, 32'h100);
  endtask

  task automatic t_rearm();
    do_reset();
    fire(5'b00010, 32'h200);
    write_msr(ME_BIT | 32'h0001_0000);
    chk("R11 rearm msr", msr, ME_BIT | 32'h0001_0000);
    fire(5'b10000, 32'h300);
    chk("R11 second req", {31'd0, req}, 32'h1);
    chk("R11 second srr1", srr1, want_srr1(5'b10000, ME_BIT | 32'h0001_0000));
    chk("R11 second msr", msr, 32'h0001_0001);
    chk("R11 no halt", {31'd0, halt}, 32'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_me_off();
    t_masked();
    t_second();
    t_rearm();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule